// File: doc/BRIEF.md
# Loop Counter and Abort Unit

This unit keeps the two loop counters of an instruction pump: an outer count that governs every instruction, and an inner count that governs only data-moving instructions. It also derives the zero flag from the outer count. Each cycle the pump presents at most one instruction that is on deck. The instruction comes with decoded command strobes, an immediate, the current data latch word, a move indication, the immune bit and a flag that says an abort token is waiting. The unit answers in the same cycle whether the instruction runs, whether it is skipped, or whether it is aborted and the token taken. Its counter updates take effect at the following clock edge.

An inner count greater than one makes a move run on several consecutive presentations. The unit counts down and raises a retire strobe on the final pass. A count of zero retires the move without running it. The infinite setting keeps the move running until an abort token arrives. Every retired move leaves the inner count at one. An abort clears the outer count and sets the inner count to one.

Top module: `loop_count_unit`

## Requirements
- R1: After a synchronous active-low reset, the outer count is 0, the zero flag is 1, the inner count is 1 with the infinite marker clear, and exec_en, take_token and move_done are 0 while no instruction is presented.
- R2: The zero flag is 1 exactly when the outer count is 0, and it changes in the same cycle as the count.
- R3: An executed non-move instruction loads the outer count from the immediate (olc_ld_imm) or from the data word (olc_ld_data), with the immediate winning. A data word with any bit set above the counter width loads all ones.
- R4: An executed non-move instruction with olc_dec, and no outer load strobe, lowers the outer count by one. At 0 the count stays at 0.
- R5: An executed non-move instruction loads the inner count from the immediate, sets it to infinite, or loads it from the data word, with the same data clamping as R3. The priority is immediate, then infinite, then data.
- R6: When instr_valid or pred_ok is low, exec_en, take_token and move_done are 0 and no count changes.
- R7: A valid move whose predicate holds, with immune low and token_present high, is aborted. take_token and move_done are 1 and exec_en is 0. Next cycle the outer count is 0, the zero flag is 1 and the inner count is 1 (finite).
- R8: A token is never taken for an immune move or for a non-move instruction. Such an instruction proceeds as if no token were waiting.
- R9: A valid non-move instruction whose predicate holds always executes, whatever the inner count. Counter strobes presented with a move, or with an instruction that does not execute, have no effect.
- R10: A move presented with a finite inner count of 0 is skipped. exec_en is 0, move_done is 1, and the inner count becomes 1.
- R11: A move presented with a finite inner count n ≥ 1 executes on each of n consecutive presentations. The count drops by one on each pass, and move_done is 1 only on the last pass, after which the count is 1.
- R12: A move presented with the infinite inner count executes on every presentation with move_done 0, and the count stays infinite until an abort (R7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | An instruction is on deck this cycle |
| pred_ok | input | 1 | Predicate of the on-deck instruction holds |
| is_move | input | 1 | On-deck instruction is a move |
| immune | input | 1 | Immune bit of a move |
| token_present | input | 1 | An abort token waits in the holding slot |
| olc_ld_imm | input | 1 | Load outer count from immediate |
| olc_ld_data | input | 1 | Load outer count from data word |
| olc_dec | input | 1 | Decrement outer count |
| ilc_ld_imm | input | 1 | Load inner count from immediate |
| ilc_ld_inf | input | 1 | Set inner count to infinite |
| ilc_ld_data | input | 1 | Load inner count from data word |
| imm_val | input | CNT_W | Immediate count value |
| data_val | input | DATA_W | Data latch word |
| olc_value | output | CNT_W | Outer count |
| zero_flag | output | 1 | Outer count is zero |
| ilc_count | output | CNT_W | Inner count (finite part) |
| ilc_infinite | output | 1 | Inner count is infinite |
| exec_en | output | 1 | Instruction executes this cycle |
| take_token | output | 1 | Abort token consumed this cycle |
| move_done | output | 1 | Move retires this cycle |

## Verification
The hardest state to reach from the ports is an infinite inner count with a move that repeats over many presentations and is then cut off by a token, possibly at a moment when the outer count is already zero. Random stimulus alone seldom sets the count to infinite and then holds back tokens long enough. Directed sequences therefore load infinity, repeat the move with no token present, and then raise the token once with the immune bit clear and once with it set. A random phase follows. It biases token and immune rates so that both aborts and long runs happen, and it compares every output against a cycle-level model in the bench.

// File: rtl/loop_count_pkg.sv
// Package: shared constants and the verdict type of the loop counter unit.
// Assumes: one instruction at most is resolved per cycle.
package loop_count_pkg;
    localparam int CNT_W_DEF  = 6;
    localparam int DATA_W_DEF = 37;

    // Outcome of the issue decision for the on-deck instruction.
    typedef enum logic [1:0] {
        GATE_IDLE  = 2'd0,
        GATE_RUN   = 2'd1,
        GATE_SKIP  = 2'd2,
        GATE_ABORT = 2'd3
    } gate_verdict_e;
endpackage

// File: rtl/issue_gate.sv
// Module: issue_gate
// Does: decides whether the on-deck instruction runs, is skipped for a zero
// inner count, or is aborted by a waiting token.
// Assumes: the predicate is resolved upstream; only moves may be aborted.
module issue_gate
    import loop_count_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          instr_valid,
    input  logic          pred_ok,
    input  logic          is_move,
    input  logic          immune,
    input  logic          token_present,
    input  logic          ilc_zero,
    output gate_verdict_e verdict
);
    logic live;
    logic abort_hit;

    assign live      = instr_valid && pred_ok;
    assign abort_hit = live && is_move && !immune && token_present;

    // Purpose: choose the verdict, abort first, then the zero-count skip.
    always_comb begin
        if (!live)                    verdict = GATE_IDLE;
        else if (abort_hit)           verdict = GATE_ABORT;
        else if (is_move && ilc_zero) verdict = GATE_SKIP;
        else                          verdict = GATE_RUN;
    end

    AST_IMMUNE_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        (immune || !is_move) |-> verdict != GATE_ABORT); // R8
    AST_IDLE_NO_PRED: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_ok |-> verdict == GATE_IDLE); // R6
endmodule

// File: rtl/outer_counter.sv
// Module: outer_counter
// Does: holds the outer loop count and its zero flag; loads, decrements
// with a floor at zero, and clears on abort.
// Assumes: run_set is high only for an executed non-move instruction.
module outer_counter #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_set,
    input  logic             abort,
    input  logic             ld_imm,
    input  logic             ld_data,
    input  logic             dec,
    input  logic [CNT_W-1:0] imm,
    input  logic [CNT_W-1:0] data_cnt,
    output logic [CNT_W-1:0] olc,
    output logic             zero
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Purpose: register the outer count with abort taking precedence.
    always_ff @(posedge clk) begin
        if (!rst_n)                 olc <= '0;
        else if (abort)             olc <= '0;
        else if (run_set) begin
            if (ld_imm)             olc <= imm;
            else if (ld_data)       olc <= data_cnt;
            else if (dec && olc != '0) olc <= olc - ONE;
        end
    end

    assign zero = (olc == '0);

    AST_ABORT_CLEARS_OLC: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (olc == '0) && zero); // R7
    AST_DEC_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (run_set && dec && !ld_imm && !ld_data && olc == '0) |=> olc == '0); // R4
    AST_OLC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_set && !abort) |=> $stable(olc)); // R9
endmodule

// File: rtl/inner_counter.sv
// Module: inner_counter
// Does: holds the inner loop count with an infinite marker; counts down
// repeated moves and returns to one when a move retires.
// Assumes: at most one of run_set, run_move, skip_move, abort is high.
module inner_counter #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_set,
    input  logic             run_move,
    input  logic             skip_move,
    input  logic             abort,
    input  logic             ld_imm,
    input  logic             ld_inf,
    input  logic             ld_data,
    input  logic [CNT_W-1:0] imm,
    input  logic [CNT_W-1:0] data_cnt,
    output logic [CNT_W-1:0] cnt,
    output logic             inf,
    output logic             cnt_zero,
    output logic             last_pass
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assign cnt_zero  = !inf && (cnt == '0);
    assign last_pass = !inf && (cnt <= ONE);

    // Purpose: register the inner count and its infinite marker.
    always_ff @(posedge clk) begin
        if (!rst_n || abort || skip_move) begin
            cnt <= ONE;
            inf <= 1'b0;
        end else if (run_move) begin
            if (!inf) cnt <= (cnt > ONE) ? cnt - ONE : ONE;
        end else if (run_set) begin
            if (ld_imm) begin
                cnt <= imm;
                inf <= 1'b0;
            end else if (ld_inf) begin
                cnt <= '0;
                inf <= 1'b1;
            end else if (ld_data) begin
                cnt <= data_cnt;
                inf <= 1'b0;
            end
        end
    end

    AST_SKIP_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        skip_move |=> (cnt == ONE) && !inf); // R10
    AST_INF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run_move && inf) |=> inf); // R12
    AST_ABORT_ILC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (cnt == ONE) && !inf); // R7
endmodule

// File: rtl/loop_count_unit.sv
// Module: loop_count_unit (top)
// Does: joins the issue gate with the outer and inner counters, clamps the
// data word to the counter width, and produces the per-cycle strobes.
// Assumes: decode of instruction fields happens upstream.
module loop_count_unit
    import loop_count_pkg::*;
#(
    parameter int CNT_W  = CNT_W_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic              pred_ok,
    input  logic              is_move,
    input  logic              immune,
    input  logic              token_present,
    input  logic              olc_ld_imm,
    input  logic              olc_ld_data,
    input  logic              olc_dec,
    input  logic              ilc_ld_imm,
    input  logic              ilc_ld_inf,
    input  logic              ilc_ld_data,
    input  logic [CNT_W-1:0]  imm_val,
    input  logic [DATA_W-1:0] data_val,
    output logic [CNT_W-1:0]  olc_value,
    output logic              zero_flag,
    output logic [CNT_W-1:0]  ilc_count,
    output logic              ilc_infinite,
    output logic              exec_en,
    output logic              take_token,
    output logic              move_done
);
    gate_verdict_e    verdict;
    logic             ilc_zero;
    logic             ilc_last;
    logic             run_set;
    logic             run_move;
    logic             skip_move;
    logic             abort;
    logic [CNT_W-1:0] data_cnt;

    // Purpose: clamp the data word to the largest count when it overflows.
    always_comb begin
        data_cnt = (|data_val[DATA_W-1:CNT_W]) ? '1 : data_val[CNT_W-1:0];
    end

    issue_gate u_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .instr_valid   (instr_valid),
        .pred_ok       (pred_ok),
        .is_move       (is_move),
        .immune        (immune),
        .token_present (token_present),
        .ilc_zero      (ilc_zero),
        .verdict       (verdict)
    );

    assign abort     = (verdict == GATE_ABORT);
    assign skip_move = (verdict == GATE_SKIP);
    assign run_set   = (verdict == GATE_RUN) && !is_move;
    assign run_move  = (verdict == GATE_RUN) && is_move;

    outer_counter #(.CNT_W(CNT_W)) u_outer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_set  (run_set),
        .abort    (abort),
        .ld_imm   (olc_ld_imm),
        .ld_data  (olc_ld_data),
        .dec      (olc_dec),
        .imm      (imm_val),
        .data_cnt (data_cnt),
        .olc      (olc_value),
        .zero     (zero_flag)
    );

    inner_counter #(.CNT_W(CNT_W)) u_inner (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_set   (run_set),
        .run_move  (run_move),
        .skip_move (skip_move),
        .abort     (abort),
        .ld_imm    (ilc_ld_imm),
        .ld_inf    (ilc_ld_inf),
        .ld_data   (ilc_ld_data),
        .imm       (imm_val),
        .data_cnt  (data_cnt),
        .cnt       (ilc_count),
        .inf       (ilc_infinite),
        .cnt_zero  (ilc_zero),
        .last_pass (ilc_last)
    );

    assign exec_en    = run_set || run_move;
    assign take_token = abort;
    assign move_done  = abort || skip_move || (run_move && ilc_last);

    AST_TAKE_NOT_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        !(take_token && exec_en)); // R7
    AST_INF_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && is_move && ilc_infinite) |-> !move_done); // R12
    AST_NONMOVE_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && pred_ok && !is_move) |-> exec_en); // R9
endmodule

// File: tb/loop_count_unit_test.sv
module loop_count_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 37;
    localparam int CW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic instr_valid = 0, pred_ok = 0, is_move = 0, immune = 0, token_present = 0;
    logic olc_ld_imm = 0, olc_ld_data = 0, olc_dec = 0;
    logic ilc_ld_imm = 0, ilc_ld_inf = 0, ilc_ld_data = 0;
    logic [CW-1:0] imm_val = '0;
    logic [DW-1:0] data_val = '0;
    logic [CW-1:0] olc_value, ilc_count;
    logic zero_flag, ilc_infinite, exec_en, take_token, move_done;

    int n_checks = 0;
    int n_fail = 0;
    int m_olc, m_cnt;
    bit m_inf;

    always #(CLK_PERIOD/2) clk = ~clk;

    loop_count_unit uut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .pred_ok(pred_ok),
        .is_move(is_move), .immune(immune), .token_present(token_present),
        .olc_ld_imm(olc_ld_imm), .olc_ld_data(olc_ld_data), .olc_dec(olc_dec),
        .ilc_ld_imm(ilc_ld_imm), .ilc_ld_inf(ilc_ld_inf), .ilc_ld_data(ilc_ld_data),
        .imm_val(imm_val), .data_val(data_val), .olc_value(olc_value),
        .zero_flag(zero_flag), .ilc_count(ilc_count), .ilc_infinite(ilc_infinite),
        .exec_en(exec_en), .take_token(take_token), .move_done(move_done)
    );

    task automatic check(string tag, string what, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int clamp_data(logic [DW-1:0] d);
        return ((d >> CW) != 0) ? (1 << CW) - 1 : int'(d[CW-1:0]);
    endfunction

    // cmd bits: 0 olc imm, 1 olc data, 2 olc dec, 3 ilc imm, 4 ilc inf, 5 ilc data
    task automatic step(bit v, bit p, bit mv, bit imb, bit tok, bit [5:0] cmd,
                        logic [CW-1:0] imm, logic [DW-1:0] data);
        bit ab, zc, sk, rn, dn;
        string tag, stag;
        instr_valid = v; pred_ok = p; is_move = mv; immune = imb; token_present = tok;
        olc_ld_imm = cmd[0]; olc_ld_data = cmd[1]; olc_dec = cmd[2];
        ilc_ld_imm = cmd[3]; ilc_ld_inf = cmd[4]; ilc_ld_data = cmd[5];
        imm_val = imm; data_val = data;
        #1;
        ab = v && p && mv && !imb && tok;
        zc = !m_inf && m_cnt == 0;
        sk = v && p && mv && !ab && zc;
        rn = v && p && !ab && (!mv || !zc);
        dn = ab || sk || (rn && mv && !m_inf && m_cnt <= 1);
        if (!(v && p))            tag = "R6";
        else if (ab)              tag = "R7";
        else if (tok)             tag = "R8";
        else if (!mv)             tag = "R9";
        else if (m_inf)           tag = "R12";
        else if (zc)              tag = "R10";
        else                      tag = "R11";
        stag = tag;
        if (rn && !mv) begin
            if (cmd[3] || cmd[4] || cmd[5]) stag = "R5";
            else if (cmd[0] || cmd[1])     stag = "R3";
            else if (cmd[2])               stag = "R4";
        end
        check(tag, "exec_en", exec_en, rn);
        check(tag, "take_token", take_token, ab);
        check(tag, "move_done", move_done, dn);
        if (ab) begin
            m_olc = 0; m_cnt = 1; m_inf = 0;
        end else if (sk) begin
            m_cnt = 1;
        end else if (rn && mv) begin
            if (!m_inf) m_cnt = (m_cnt > 1) ? m_cnt - 1 : 1;
        end else if (rn) begin
            if (cmd[0])                    m_olc = int'(imm);
            else if (cmd[1])               m_olc = clamp_data(data);
            else if (cmd[2] && m_olc != 0) m_olc = m_olc - 1;
            if (cmd[3])      begin m_cnt = int'(imm); m_inf = 0; end
            else if (cmd[4]) begin m_cnt = 0; m_inf = 1; end
            else if (cmd[5]) begin m_cnt = clamp_data(data); m_inf = 0; end
        end
        @(negedge clk);
        check(stag, "olc_value", olc_value, m_olc);
        check("R2", "zero_flag", zero_flag, m_olc == 0);
        check(stag, "ilc_count", ilc_count, m_cnt);
        check(stag, "ilc_infinite", ilc_infinite, m_inf);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog actual=timeout expected=finished");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        m_olc = 0; m_cnt = 1; m_inf = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "olc_value", olc_value, 0);
        check("R1", "zero_flag", zero_flag, 1);
        check("R1", "ilc_count", ilc_count, 1);
        check("R1", "ilc_infinite", ilc_infinite, 0);
        check("R1", "exec_en", exec_en, 0);
        check("R1", "take_token", take_token, 0);
        check("R1", "move_done", move_done, 0);

        // R3 / R2: outer load from immediate, then decrement (R4)
        step(1, 1, 0, 0, 0, 6'b000001, 6'd2, '0);
        step(1, 1, 0, 0, 0, 6'b000100, 6'd0, '0);
        step(1, 1, 0, 0, 0, 6'b000100, 6'd0, '0);
        step(1, 1, 0, 0, 0, 6'b000100, 6'd0, '0); // R4 floor at zero
        // R3 clamp of a wide data word, and priority of immediate
        step(1, 1, 0, 0, 0, 6'b000010, 6'd0, 37'h10_0000_0005);
        step(1, 1, 0, 0, 0, 6'b000111, 6'd9, 37'h3);
        // R6: predicate false with strobes
        step(1, 0, 0, 0, 0, 6'b111111, 6'd1, '0);
        step(0, 1, 1, 0, 1, 6'b111111, 6'd1, '0);
        // R11: inner count 3, three passes
        step(1, 1, 0, 0, 0, 6'b001000, 6'd3, '0);
        step(1, 1, 1, 0, 0, 6'b000000, 6'd0, '0);
        step(1, 1, 1, 0, 0, 6'b000000, 6'd0, '0);
        step(1, 1, 1, 0, 0, 6'b000000, 6'd0, '0);
        // R10: zero count skips; R9: strobes on move ignored
        step(1, 1, 0, 0, 0, 6'b001000, 6'd0, '0);
        step(1, 1, 1, 0, 0, 6'b111111, 6'd7, '0);
        // R5: data load clamps, infinity
        step(1, 1, 0, 0, 0, 6'b100000, 6'd0, 37'h40);
        step(1, 1, 0, 0, 0, 6'b110000, 6'd0, 37'h2);
        // R12: infinite run, then immune token (R8), then abort (R7)
        step(1, 1, 1, 0, 0, 6'b000000, 6'd0, '0);
        step(1, 1, 1, 0, 0, 6'b000000, 6'd0, '0);
        step(1, 1, 1, 1, 1, 6'b000000, 6'd0, '0);
        step(1, 1, 0, 0, 1, 6'b000001, 6'd4, '0);
        step(1, 1, 1, 0, 1, 6'b000000, 6'd0, '0);

        for (int i = 0; i < 4000; i++) begin
            bit [5:0] cmd;
            logic [DW-1:0] d;
            cmd = ($urandom_range(1, 0) == 0) ? 6'b0 : 6'($urandom);
            d = ($urandom_range(1, 0) == 0) ? DW'($urandom_range(63, 0))
                                             : {5'($urandom), 32'($urandom)};
            step($urandom_range(7, 0) != 0, $urandom_range(3, 0) != 0,
                 $urandom_range(1, 0) != 0, $urandom_range(3, 0) == 0,
                 $urandom_range(3, 0) == 0, cmd, 6'($urandom), d);
        end
        summary();
        $finish;
    end
endmodule